// File: doc/BRIEF.md
# Monitor Interrupt Status and Mask Controller

This block gathers the fault events of a hardware health monitor into two 8-bit status bytes and turns them into one active-low interrupt pin. Six supply-voltage channels are checked here against a high and a low limit each time their measurement strobe fires. Temperature and two fan-speed faults arrive as one-cycle event pulses from their own blocks. A chassis-intrusion level input is also captured. Each status bit stays set until the host reads its byte, except the chassis bit, which is held until a dedicated chassis-clear control is pulsed.

Two mask bytes, laid out like the status bytes, keep chosen bits off the interrupt. The pin is driven only while the global enable is set. A separate interrupt-hold control forces the pin inactive and freezes the monitored status while it is high. It does not touch the stored bits. The bus front end and the converter are outside this block. It sees reads as one-cycle strobes per status byte, and it sees configuration as level inputs.

Top module: `irq_status_ctrl`

## Requirements
- R1: Status byte 1 maps bit 0 to channel 0 (+2.5V), bit 1 to channel 1 (core 1), bit 2 to channel 2 (+3.3V), bit 3 to channel 3 (+5V), bit 4 to the temperature event, bit 6 to fan 0 and bit 7 to fan 1. Bit 5 always reads 0.
- R2: Status byte 2 maps bit 0 to channel 4 (+12V), bit 1 to channel 5 (negative rail / core 2) and bit 4 to chassis intrusion. Bits 2, 3, 5, 6 and 7 always read 0.
- R3: When a channel's strobe is high, its status bit is set at the next clock edge if the value is greater than the high limit, or if it is less than or equal to the low limit. A value equal to the high limit, or one above the low limit, sets nothing.
- R4: A temperature or fan event pulse sets its status bit at the next clock edge.
- R5: While a read strobe is high, the byte shows its contents unchanged. At that clock edge every non-chassis bit of that byte is cleared.
- R6: The chassis bit is set at each edge where the chassis input is high. Reads leave it alone. It is cleared only at an edge where the chassis-clear control is high and the chassis input is low.
- R7: An event arriving in the same cycle as the clear of its bit leaves the bit set. This applies both to a read-clear and to a chassis clear.
- R8: A 1 in a mask bit keeps the matching status bit from driving the interrupt. Bit 7 of mask byte 2 is not an interrupt mask and never suppresses anything.
- R9: One clock after the enable is high, the hold is low and any unmasked status bit is 1, the interrupt output is driven low. Otherwise it is high one clock later. After a read clears the last unmasked bit, it returns high.
- R10: While the interrupt-hold control is high, the interrupt output is high one clock later. Voltage, temperature and fan events are ignored, so status changes only through reads and chassis activity.
- R11: After reset, both status bytes are 0 and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vmeas_vld | input | NUM_VCH | Per-channel measurement strobe |
| vmeas_val | input | NUM_VCH*DATA_W | Packed channel readings, channel 0 in the low bits |
| vlim_hi | input | NUM_VCH*DATA_W | Packed high limits |
| vlim_lo | input | NUM_VCH*DATA_W | Packed low limits |
| temp_evt | input | 1 | Temperature fault pulse |
| fan_evt | input | 2 | Fan fault pulses, bit 0 fan 0 |
| chassis_in | input | 1 | Chassis intrusion level |
| rd_stat1 | input | 1 | Read strobe for status byte 1 |
| rd_stat2 | input | 1 | Read strobe for status byte 2 |
| chassis_clr | input | 1 | Clears the sticky chassis bit |
| cfg_int_en | input | 1 | Global interrupt enable |
| cfg_int_clr | input | 1 | Interrupt hold / monitoring halt |
| mask1 | input | 8 | Interrupt mask for status byte 1 |
| mask2 | input | 8 | Interrupt mask for status byte 2 (bit 7 not a mask) |
| stat1 | output | 8 | Status byte 1 |
| stat2 | output | 8 | Status byte 2 |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status bit is due one clock edge after its strobe, event or clear input. The interrupt pin adds a second register, so it follows a status change one edge later and a configuration or mask change one edge after that change. The bench drives inputs just after the falling edge and keeps a behavioural model updated at each rising edge. It compares both status bytes and the pin at every following falling edge. Directed steps check literal values at the same points. Where the pin lags status by one more edge, as after a read-clear, a directed step waits one extra cycle before sampling.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int STAT_W = 8;
   localparam int PAIR_W = 2 * STAT_W;

   // implemented bits of each status byte
   localparam logic [STAT_W-1:0] S1_VALID  = 8'b1101_1111;
   localparam logic [STAT_W-1:0] S2_VALID  = 8'b0001_0011;
   // bits that survive a read and need the chassis clear
   localparam logic [STAT_W-1:0] S2_STICKY = 8'b0001_0000;

   // event positions within {stat2, stat1}
   localparam logic [PAIR_W-1:0] TEMP_M = 16'h0010;
   localparam logic [PAIR_W-1:0] FAN0_M = 16'h0040;
   localparam logic [PAIR_W-1:0] FAN1_M = 16'h0080;
   localparam logic [PAIR_W-1:0] CHS_M  = 16'h1000;

   // bit position of each voltage channel within {stat2, stat1}
   function automatic int vch_pos(input int ch);
      case (ch)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         3:       return 3;
         4:       return 8;
         default: return 9;
      endcase
   endfunction

endpackage

// File: rtl/volt_window_cmp.sv
module volt_window_cmp
   #(parameter int DATA_W   = 8,
     parameter bit LOW_INCL = 1'b1)
   (input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    input  logic              vld,
    output logic              err);

   logic over_hi;
   logic under_lo;

   if (DATA_W < 2) begin : g_bad_dw
      $error("volt_window_cmp: DATA_W must be at least 2");
   end

   assign over_hi = val > hi;

   if (LOW_INCL) begin : g_lo_incl
      assign under_lo = val <= lo;
   end else begin : g_lo_excl
      assign under_lo = val < lo;
   end

   assign err = vld & (over_hi | under_lo);

endmodule

// File: rtl/stat_reg.sv
module stat_reg
   #(parameter int         W      = 8,
     parameter logic [W-1:0] VALID  = '1,
     parameter logic [W-1:0] STICKY = '0)
   (input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         rd_clr,
    input  logic         sticky_clr,
    output logic [W-1:0] q);

   logic [W-1:0] q_r;
   logic [W-1:0] keep;
   logic [W-1:0] q_nxt;

   if (W < 1) begin : g_bad_w
      $error("stat_reg: W must be positive");
   end

   always_comb begin
      keep = q_r;
      if (rd_clr)     keep &= STICKY;
      if (sticky_clr) keep &= ~STICKY;
      q_nxt = (keep | set) & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
   end

   assign q = q_r;

   // R1 / R2: reserved positions never hold a 1
   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (q_r & ~VALID) == '0);

   // R5: a read with no new event empties the non-sticky bits
   p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && set == '0) |=> (q_r & ~STICKY) == '0);

   // R6: sticky bits only fall when the sticky clear was high
   p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky_clr |=> (($past(q_r) & STICKY) & ~q_r) == '0);

   // R7: a set always lands, whatever clear comes with it
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> (q_r & $past(set & VALID)) == $past(set & VALID));

endmodule

// File: rtl/irq_out.sv
module irq_out
   #(parameter int         W       = 8,
     parameter logic [W-1:0] VALID1  = '1,
     parameter logic [W-1:0] VALID2  = '1,
     parameter bit         REG_OUT = 1'b1)
   (input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat1,
    input  logic [W-1:0] stat2,
    input  logic [W-1:0] mask1,
    input  logic [W-1:0] mask2,
    input  logic         en,
    input  logic         hold,
    output logic         irq_n);

   logic pend;
   logic want;

   assign pend = (|(stat1 & ~mask1 & VALID1)) | (|(stat2 & ~mask2 & VALID2));
   assign want = en & ~hold & pend;

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~want;
      end
      assign irq_n = irq_q;

      // R9: disabled output stays inactive
      p_irq_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> irq_n);

      // R10: hold forces the pin inactive
      p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         hold |=> irq_n);

      // R8: fully masked status never drives the pin
      p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat1 & ~mask1) == '0 && (stat2 & ~mask2) == '0) |=> irq_n);
   end else begin : g_comb
      assign irq_n = ~want;
   end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irqc_pkg::*;
   #(parameter int DATA_W   = 8,
     parameter int NUM_VCH  = 6,
     parameter bit LOW_INCL = 1'b1,
     parameter bit IRQ_REG  = 1'b1)
   (input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_VCH-1:0]        vmeas_vld,
    input  logic [NUM_VCH*DATA_W-1:0] vmeas_val,
    input  logic [NUM_VCH*DATA_W-1:0] vlim_hi,
    input  logic [NUM_VCH*DATA_W-1:0] vlim_lo,
    input  logic                      temp_evt,
    input  logic [1:0]                fan_evt,
    input  logic                      chassis_in,
    input  logic                      rd_stat1,
    input  logic                      rd_stat2,
    input  logic                      chassis_clr,
    input  logic                      cfg_int_en,
    input  logic                      cfg_int_clr,
    input  logic [STAT_W-1:0]         mask1,
    input  logic [STAT_W-1:0]         mask2,
    output logic [STAT_W-1:0]         stat1,
    output logic [STAT_W-1:0]         stat2,
    output logic                      irq_n);

   logic [NUM_VCH-1:0] verr;
   logic [PAIR_W-1:0]  vmap [NUM_VCH];
   logic [PAIR_W-1:0]  set_all;
   logic [PAIR_W-1:0]  stat_all;
   logic [STAT_W-1:0]  q1;
   logic [STAT_W-1:0]  q2;

   if (NUM_VCH != 6) begin : g_bad_nv
      $error("irq_status_ctrl: status layout holds exactly six channels");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("irq_status_ctrl: DATA_W must be at least 2");
   end

   for (genvar i = 0; i < NUM_VCH; i++) begin : g_vch
      localparam logic [PAIR_W-1:0] ONEHOT = PAIR_W'(1) << vch_pos(i);

      volt_window_cmp #(.DATA_W(DATA_W), .LOW_INCL(LOW_INCL)) u_cmp (
         .val (vmeas_val[i*DATA_W +: DATA_W]),
         .hi  (vlim_hi[i*DATA_W +: DATA_W]),
         .lo  (vlim_lo[i*DATA_W +: DATA_W]),
         .vld (vmeas_vld[i]),
         .err (verr[i]));

      assign vmap[i] = verr[i] ? ONEHOT : '0;

      // R3: a reading above the high limit flags its channel
      p_vwin_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (vmeas_vld[i] && !cfg_int_clr &&
          vmeas_val[i*DATA_W +: DATA_W] > vlim_hi[i*DATA_W +: DATA_W])
         |=> |(stat_all & ONEHOT));

      if (LOW_INCL) begin : g_lo_chk
         // R3: a reading at or under the low limit flags its channel
         p_vwin_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (vmeas_vld[i] && !cfg_int_clr &&
             vmeas_val[i*DATA_W +: DATA_W] <= vlim_lo[i*DATA_W +: DATA_W])
            |=> |(stat_all & ONEHOT));
      end
   end

   always_comb begin
      set_all = '0;
      if (!cfg_int_clr) begin
         for (int k = 0; k < NUM_VCH; k++) set_all |= vmap[k];
         if (temp_evt)   set_all |= TEMP_M;
         if (fan_evt[0]) set_all |= FAN0_M;
         if (fan_evt[1]) set_all |= FAN1_M;
      end
      if (chassis_in) set_all |= CHS_M;
   end

   stat_reg #(.W(STAT_W), .VALID(S1_VALID), .STICKY('0)) u_stat1 (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (set_all[STAT_W-1:0]),
      .rd_clr     (rd_stat1),
      .sticky_clr (1'b0),
      .q          (q1));

   stat_reg #(.W(STAT_W), .VALID(S2_VALID), .STICKY(S2_STICKY)) u_stat2 (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (set_all[PAIR_W-1:STAT_W]),
      .rd_clr     (rd_stat2),
      .sticky_clr (chassis_clr),
      .q          (q2));

   irq_out #(.W(STAT_W), .VALID1(S1_VALID), .VALID2(S2_VALID & 8'h7F),
             .REG_OUT(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .stat1 (q1),
      .stat2 (q2),
      .mask1 (mask1),
      .mask2 (mask2),
      .en    (cfg_int_en),
      .hold  (cfg_int_clr),
      .irq_n (irq_n));

   assign stat_all = {q2, q1};
   assign stat1    = q1;
   assign stat2    = q2;

   // R4: temperature and fan pulses land one edge later
   p_evt_temp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_evt && !cfg_int_clr) |=> stat1[4]);
   p_evt_fan_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fan_evt[1] && !cfg_int_clr) |=> stat1[7]);

   // R6: chassis level is captured even while monitoring halts
   p_chs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chassis_in |=> stat2[4]);

   // R10: halted monitoring leaves status byte 1 frozen without reads
   p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_int_clr && !rd_stat1) |=> stat1 == $past(stat1));

endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
   localparam int DW = 8;
   localparam int NV = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic [NV-1:0]    vmeas_vld;
   logic [NV*DW-1:0] vmeas_val, vlim_hi, vlim_lo;
   logic             temp_evt, chassis_in, rd_stat1, rd_stat2, chassis_clr;
   logic [1:0]       fan_evt;
   logic             cfg_int_en, cfg_int_clr;
   logic [7:0]       mask1, mask2, stat1, stat2;
   logic             irq_n;

   irq_status_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .vmeas_vld(vmeas_vld), .vmeas_val(vmeas_val),
      .vlim_hi(vlim_hi), .vlim_lo(vlim_lo), .temp_evt(temp_evt), .fan_evt(fan_evt),
      .chassis_in(chassis_in), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
      .chassis_clr(chassis_clr), .cfg_int_en(cfg_int_en), .cfg_int_clr(cfg_int_clr),
      .mask1(mask1), .mask2(mask2), .stat1(stat1), .stat2(stat2), .irq_n(irq_n));

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 0;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // behavioural reference, updated at every rising edge
   int m1, m2;
   bit mirq_n;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1 = 0; m2 = 0; mirq_n = 1;
      end else begin
         int s1, s2, v, h, l;
         bit pend;
         pend = ((m1 & ~int'(mask1) & 'hDF) | (m2 & ~int'(mask2) & 'h13)) != 0;
         mirq_n = !(cfg_int_en && !cfg_int_clr && pend);
         s1 = 0; s2 = 0;
         if (!cfg_int_clr) begin
            for (int ch = 0; ch < NV; ch++) begin
               v = vmeas_val[ch*DW +: DW];
               h = vlim_hi[ch*DW +: DW];
               l = vlim_lo[ch*DW +: DW];
               if (vmeas_vld[ch] && (v > h || v <= l)) begin
                  if (ch < 4) s1 |= 1 << ch;
                  else        s2 |= 1 << (ch - 4);
               end
            end
            if (temp_evt)   s1 |= 'h10;
            if (fan_evt[0]) s1 |= 'h40;
            if (fan_evt[1]) s1 |= 'h80;
         end
         if (chassis_in) s2 |= 'h10;
         m1 = (rd_stat1 ? 0 : m1) | s1;
         m2 = (chassis_clr ? 0 : (m2 & 'h10)) | (rd_stat2 ? 0 : (m2 & 'h03)) | s2;
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 stat1 vs model", {8'h0, stat1}, 16'(m1));
         chk("R2 stat2 vs model", {8'h0, stat2}, 16'(m2));
         chk("R9 irq_n vs model", {15'h0, irq_n}, {15'h0, mirq_n});
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic vpulse(input int ch, input int val, input int hi, input int lo);
      vmeas_val[ch*DW +: DW] = DW'(val);
      vlim_hi[ch*DW +: DW]   = DW'(hi);
      vlim_lo[ch*DW +: DW]   = DW'(lo);
      vmeas_vld[ch]          = 1'b1;
      step();
      vmeas_vld = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 0; vmeas_vld = '0; vmeas_val = '0; vlim_hi = '0; vlim_lo = '0;
      temp_evt = 0; fan_evt = '0; chassis_in = 0; rd_stat1 = 0; rd_stat2 = 0;
      chassis_clr = 0; cfg_int_en = 0; cfg_int_clr = 0; mask1 = '0; mask2 = '0;
      repeat (3) step();
      rst_n = 1;
      chk("R11 stat1 after reset", 16'(stat1), 16'h0);
      chk("R11 stat2 after reset", 16'(stat2), 16'h0);
      chk("R11 irq_n after reset", 16'(irq_n), 16'h1);

      vpulse(0, 100, 100, 50); chk("R3 equal to high limit", 16'(stat1), 16'h00);
      vpulse(0, 101, 100, 50); chk("R3 above high limit", 16'(stat1), 16'h01);
      rd_stat1 = 1; chk("R5 read shows contents", 16'(stat1), 16'h01);
      step(); rd_stat1 = 0; chk("R5 cleared after read", 16'(stat1), 16'h00);
      vpulse(3, 50, 200, 50); chk("R3 equal to low limit", 16'(stat1), 16'h08);
      vpulse(1, 51, 200, 50); chk("R3 just above low limit", 16'(stat1), 16'h08);
      vpulse(4, 0, 200, 0);   chk("R2 channel 4 bit0", 16'(stat2), 16'h01);
      vpulse(5, 255, 254, 0); chk("R2 channel 5 bit1", 16'(stat2), 16'h03);

      temp_evt = 1; fan_evt = 2'b11; step(); temp_evt = 0; fan_evt = '0;
      chk("R4 R1 temp and fan bits, bit5 zero", 16'(stat1), 16'hD8);

      step(); chk("R9 disabled pin idle", 16'(irq_n), 16'h1);
      cfg_int_en = 1; step(); chk("R9 enabled pending drives low", 16'(irq_n), 16'h0);
      mask1 = 8'hFF; mask2 = 8'hFF; step(); chk("R8 all masked", 16'(irq_n), 16'h1);
      mask2 = 8'h80; step(); chk("R8 mask2 bit7 suppresses nothing", 16'(irq_n), 16'h0);
      mask2 = 8'hFF; mask1 = 8'hF7; step(); chk("R8 single unmasked bit", 16'(irq_n), 16'h0);

      cfg_int_clr = 1; step(); chk("R10 hold forces pin high", 16'(irq_n), 16'h1);
      vpulse(2, 255, 10, 0); chk("R10 voltage ignored in hold", 16'(stat1), 16'hD8);
      chassis_in = 1; step(); chassis_in = 0;
      chk("R6 chassis captured in hold", 16'(stat2), 16'h13);
      cfg_int_clr = 0; step(); chk("R10 release restores pin", 16'(irq_n), 16'h0);

      rd_stat1 = 1; rd_stat2 = 1; step(); rd_stat1 = 0; rd_stat2 = 0;
      chk("R5 stat1 emptied", 16'(stat1), 16'h00);
      chk("R6 chassis survives read", 16'(stat2), 16'h10);
      step(); chk("R9 pin idle after read clear", 16'(irq_n), 16'h1);
      mask2 = 8'h00; step(); chk("R8 chassis unmasked", 16'(irq_n), 16'h0);
      chassis_clr = 1; step(); chassis_clr = 0;
      chk("R6 chassis cleared by control", 16'(stat2), 16'h00);

      rd_stat1 = 1; temp_evt = 1; step(); rd_stat1 = 0; temp_evt = 0;
      chk("R7 event beats read clear", 16'(stat1), 16'h10);
      chassis_in = 1; chassis_clr = 1; step(); chassis_in = 0; chassis_clr = 0;
      chk("R7 chassis set beats clear", 16'(stat2), 16'h10);

      for (int c = 0; c < 3000; c++) begin
         for (int ch = 0; ch < NV; ch++) begin
            vmeas_val[ch*DW +: DW] = DW'($urandom);
            vlim_hi[ch*DW +: DW]   = DW'($urandom_range(120, 255));
            vlim_lo[ch*DW +: DW]   = DW'($urandom_range(0, 120));
            vmeas_vld[ch]          = ($urandom_range(0, 7) == 0);
         end
         temp_evt    = ($urandom_range(0, 15) == 0);
         fan_evt     = {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
         chassis_in  = ($urandom_range(0, 31) == 0);
         chassis_clr = ($urandom_range(0, 15) == 0);
         rd_stat1    = ($urandom_range(0, 7) == 0);
         rd_stat2    = ($urandom_range(0, 7) == 0);
         cfg_int_en  = ($urandom_range(0, 9) != 0);
         cfg_int_clr = ($urandom_range(0, 15) == 0);
         if ($urandom_range(0, 31) == 0) begin
            mask1 = 8'($urandom);
            mask2 = 8'($urandom);
         end
         step();
      end
      finish_run();
   end

endmodule